// File: doc/BRIEF.md
# Receive DMA Ring with Four Register Slots

This block moves received Ethernet frames into memory using four buffer slots. The descriptors are hardware registers, not a list in memory. Each slot has a control word and a status word. The control word holds the buffer base address, an enable bit, a done bit, and a report of which slot the hardware fills next. Software arms a slot by writing a 64-byte-aligned address with the enable bit set. The block takes the incoming byte stream and writes each byte to the buffer of the current slot through a simple valid/ready memory write port.

When the last byte of a frame is accepted, the block does the following in the same clock edge:
- It writes the status word: the frame length, the error flags, the multicast flag, the broadcast flag and a missed-frame flag.
- It sets the slot's done bit and clears its enable bit.
- It moves on to the next slot, wrapping modulo four.

A one-cycle completion pulse then tells the interrupt logic. If a frame starts while the current slot is not armed, the whole frame is dropped. The next frame that is delivered then carries the missed-frame flag.

Top module: `rxr_ring`

## Requirements
- R1: After reset, every control word and every status word reads 0, and `slot_done_pulse` is low.
- R2: Register address bits [2:1] select the slot; bit 0 selects the word (0 = control, 1 = status). The status word is read-only: writes to it have no effect.
- R3: A control write does three things: it stores data bits 31:6 as the buffer base, it stores bit 0 as the enable bit, and it clears the done bit (bit 1). Data bits 5:1 are ignored. A control read returns {base[31:6], 2'b00, next-slot index in bits 3:2, done in bit 1, enable in bit 0}.
- R4: Each accepted byte of a delivered frame gives one memory write. The address is base*64 + byte offset and the data is that byte. `rx_ready` equals `mem_ready` while a write is presented, and is 1 otherwise.
- R5: On the last byte, the slot's status bits 13:0 take the frame length in bytes, done is set, enable is cleared, and `slot_done_pulse` is high for exactly the following cycle.
- R6: Slots are filled in the order 0, 1, 2, 3, 0, and so on. The next-slot index in control bits 3:2 advances by one, modulo four, only when a slot completes.
- R7: `rx_err` bits sampled with the last byte map into status as follows: bit0→14 (watchdog), bit1→15 (runt), bit2→16 (over-length), bit3→17 (collision), bit4→19 (MII error), bit5→21 (CRC), bit6→24 (length error), bit7→26 (unknown control frame). `rx_mcast`→27 and `rx_bcast`→28. All other status bits are 0 unless R8 or R9 sets them.
- R8: A frame whose first byte arrives while the current slot is not enabled is dropped whole. It makes no memory writes, gives no pulse, and leaves the index and all slot registers unchanged, even if the slot is armed partway through the frame.
- R9: After one or more dropped frames, the next delivered frame has status bit 31 set. The frame delivered after that has bit 31 clear.
- R10: Bytes at offsets of `BUF_BYTES` or more are not written to memory. The length still counts them, and status bit 16 is set.
- R11: A slot that has completed can be re-armed with base|1. It then reads done=0, enable=1 and takes the next frame that reaches its turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address {slot, word select} |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address {slot, word select} |
| reg_rdata | output | 32 | Read data (combinational) |
| rx_valid | input | 1 | Frame byte valid |
| rx_ready | output | 1 | Frame byte accepted |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Last byte of frame |
| rx_err | input | 8 | Error flags, sampled with the last byte |
| rx_mcast | input | 1 | Multicast indication, sampled with the last byte |
| rx_bcast | input | 1 | Broadcast indication, sampled with the last byte |
| mem_valid | output | 1 | Memory byte write valid |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 32 | Byte address |
| mem_data | output | 8 | Byte data |
| slot_done_pulse | output | 1 | One-cycle slot completion pulse |

## Verification
The bench goes after several corner cases, and each has a typical failure:
- **Wrap from slot 3 to slot 0.** An index that does not wrap modulo four would write into a fifth, non-existent slot.
- **Dropped frame armed mid-frame.** A design that decides per byte instead of at the frame start would leak a partial frame into memory.
- **Missed flag.** A flag that never clears would mark the frame after the recovery frame too.
- **Over-length frame.** A design that does not stop at the buffer end would write past the buffer, and one that stops counting would report a short length.
- **Memory back-pressure.** Random `mem_ready` stalls check that a held byte is neither lost nor written twice.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int SLOTS   = 4;
    localparam int IDX_W   = 2;
    localparam int BASE_W  = 26;
    localparam int LEN_W   = 14;

    typedef logic [IDX_W-1:0] slot_idx_t;

    // bit 0 of the input flag vector is the last field listed
    typedef struct packed {
        logic unk_ctrl;
        logic len_err;
        logic crc;
        logic mii;
        logic coll;
        logic overlen;
        logic runt;
        logic wdog;
    } rx_err_t;

    function automatic logic [31:0] pack_status(
        input logic [LEN_W-1:0] len,
        input rx_err_t          e,
        input logic             mc,
        input logic             bc,
        input logic             missed
    );
        logic [31:0] s;
        s        = '0;
        s[13:0]  = len;
        s[14]    = e.wdog;
        s[15]    = e.runt;
        s[16]    = e.overlen;
        s[17]    = e.coll;
        s[19]    = e.mii;
        s[21]    = e.crc;
        s[24]    = e.len_err;
        s[26]    = e.unk_ctrl;
        s[27]    = mc;
        s[28]    = bc;
        s[31]    = missed;
        return s;
    endfunction
endpackage

// File: rtl/rxr_slot_bank.sv
module rxr_slot_bank
    import rxr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  slot_idx_t                     wr_slot,
    input  logic [BASE_W-1:0]             wr_base,
    input  logic                          wr_arm,
    input  logic                          fin,
    input  slot_idx_t                     fin_slot,
    input  logic [31:0]                   fin_status,
    output logic [SLOTS-1:0]              slot_en,
    output logic [SLOTS-1:0]              slot_done,
    output logic [SLOTS-1:0][BASE_W-1:0]  slot_base,
    output logic [SLOTS-1:0][31:0]        slot_stat
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic hit_wr, hit_fin;
        assign hit_wr  = wr_en && (wr_slot == slot_idx_t'(i));
        assign hit_fin = fin && (fin_slot == slot_idx_t'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_en[i]   <= 1'b0;
                slot_done[i] <= 1'b0;
                slot_base[i] <= '0;
                slot_stat[i] <= '0;
            end else begin
                if (hit_wr) begin
                    slot_base[i] <= wr_base;
                    slot_en[i]   <= wr_arm;
                    slot_done[i] <= 1'b0;
                end else if (hit_fin) begin
                    slot_en[i]   <= 1'b0;
                    slot_done[i] <= 1'b1;
                end
                if (hit_fin)
                    slot_stat[i] <= fin_status;
            end
        end
    end
endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 1536
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_last,
    input  logic [7:0]         in_err,
    input  logic               in_mcast,
    input  logic               in_bcast,
    output logic               in_ready,
    input  logic               cur_en,
    input  logic [BASE_W-1:0]  cur_base,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [31:0]        mem_addr,
    output logic [7:0]         mem_data,
    output logic               fin,
    output logic [31:0]        fin_status,
    output slot_idx_t          cur_idx,
    output logic               done_pulse
);
    localparam logic [LEN_W:0]   BUF_LIM = (LEN_W+1)'(BUF_BYTES);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic             in_frame, drop_r, missed_pend;
    logic [LEN_W-1:0] offset, len_next;
    logic             drop_now, fits, beat;
    rx_err_t          err_v;

    assign drop_now  = in_frame ? drop_r : !cur_en;
    assign fits      = {1'b0, offset} < BUF_LIM;
    assign mem_valid = in_valid && !drop_now && fits;
    assign in_ready  = mem_valid ? mem_ready : 1'b1;
    assign beat      = in_valid && in_ready;
    assign mem_addr  = {cur_base, 6'b0} + 32'(offset);
    assign mem_data  = in_data;
    assign len_next  = (offset == LEN_MAX) ? offset : offset + 1'b1;
    assign fin       = beat && in_last && !drop_now;

    always_comb begin
        err_v = rx_err_t'(in_err);
        if ({1'b0, len_next} > BUF_LIM)
            err_v.overlen = 1'b1;
    end

    assign fin_status = pack_status(len_next, err_v, in_mcast, in_bcast, missed_pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame    <= 1'b0;
            drop_r      <= 1'b0;
            offset      <= '0;
            missed_pend <= 1'b0;
            cur_idx     <= '0;
            done_pulse  <= 1'b0;
        end else begin
            done_pulse <= fin;
            if (beat) begin
                if (in_last) begin
                    in_frame <= 1'b0;
                    offset   <= '0;
                end else begin
                    in_frame <= 1'b1;
                    drop_r   <= drop_now;
                    offset   <= len_next;
                end
                if (drop_now)
                    missed_pend <= 1'b1;
                else if (in_last)
                    missed_pend <= 1'b0;
                if (fin)
                    cur_idx <= cur_idx + 1'b1;
            end
        end
    end

    assert_idx_step_R6: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> cur_idx == $past(cur_idx) + 2'd1);
    assert_idx_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done_pulse |-> $stable(cur_idx));
endmodule

// File: rtl/rxr_ring.sv
module rxr_ring
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 1536
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic [7:0]  rx_err,
    input  logic        rx_mcast,
    input  logic        rx_bcast,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_data,
    output logic        slot_done_pulse
);
    logic [SLOTS-1:0]             slot_en, slot_done;
    logic [SLOTS-1:0][BASE_W-1:0] slot_base;
    logic [SLOTS-1:0][31:0]       slot_stat;
    slot_idx_t                    cur_idx, rd_slot;
    logic                         fin;
    logic [31:0]                  fin_status;

    rxr_slot_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr && !reg_waddr[0]),
        .wr_slot    (reg_waddr[2:1]),
        .wr_base    (reg_wdata[31:6]),
        .wr_arm     (reg_wdata[0]),
        .fin        (fin),
        .fin_slot   (cur_idx),
        .fin_status (fin_status),
        .slot_en    (slot_en),
        .slot_done  (slot_done),
        .slot_base  (slot_base),
        .slot_stat  (slot_stat)
    );

    rxr_frame_ctl #(.BUF_BYTES(BUF_BYTES)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (rx_valid),
        .in_data    (rx_data),
        .in_last    (rx_last),
        .in_err     (rx_err),
        .in_mcast   (rx_mcast),
        .in_bcast   (rx_bcast),
        .in_ready   (rx_ready),
        .cur_en     (slot_en[cur_idx]),
        .cur_base   (slot_base[cur_idx]),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .fin        (fin),
        .fin_status (fin_status),
        .cur_idx    (cur_idx),
        .done_pulse (slot_done_pulse)
    );

    assign rd_slot = reg_raddr[2:1];
    always_comb begin
        if (reg_raddr[0])
            reg_rdata = slot_stat[rd_slot];
        else
            reg_rdata = {slot_base[rd_slot], 2'b00, cur_idx, slot_done[rd_slot], slot_en[rd_slot]};
    end

    // R8: no byte reaches memory unless the slot being filled is armed
    assert_write_armed_R8: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !$past(reg_wr) |-> slot_en[cur_idx]);
    // R5: a completion leaves a non-zero length in the finished slot
    assert_len_set_R5: assert property (@(posedge clk) disable iff (rst)
        slot_done_pulse |-> slot_stat[$past(cur_idx)][13:0] != 14'd0);
    // R5: the finished slot shows done unless software rewrote it
    assert_done_flag_R5: assert property (@(posedge clk) disable iff (rst)
        slot_done_pulse && !$past(reg_wr) |-> slot_done[$past(cur_idx)]);
endmodule

// File: tb/tb_rxr_ring.sv
`timescale 1ns/1ps
module tb_rxr_ring;
    localparam int BUF = 128;

    logic        clk = 0, rst = 1;
    logic        reg_wr = 0;
    logic [2:0]  reg_waddr = 0, reg_raddr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        rx_valid = 0, rx_ready, rx_last = 0, rx_mcast = 0, rx_bcast = 0;
    logic [7:0]  rx_data = 0, rx_err = 0;
    logic        mem_valid, mem_ready = 0, slot_done_pulse;
    logic [31:0] mem_addr;
    logic [7:0]  mem_data;

    rxr_ring #(.BUF_BYTES(BUF)) dut (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    logic [25:0] m_base [4];
    logic        m_en [4], m_done [4];
    logic [31:0] m_stat [4];
    logic [1:0]  m_idx = 0;
    logic        m_missed = 0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(int len, logic [7:0] e, logic mc, logic bc, logic ms);
        logic [31:0] s = 0;
        s[13:0] = 14'(len);
        s[14] = e[0]; s[15] = e[1]; s[16] = e[2] | (len > BUF); s[17] = e[3];
        s[19] = e[4]; s[21] = e[5]; s[24] = e[6]; s[26] = e[7];
        s[27] = mc; s[28] = bc; s[31] = ms;
        return s;
    endfunction

    function automatic logic [31:0] exp_ctrl(int i);
        return {m_base[i], 2'b00, m_idx, m_done[i], m_en[i]};
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        rx_valid = 0; reg_wr = 1; reg_waddr = a; reg_wdata = d;
        @(posedge clk);
        #0.5 reg_wr = 0;
        if (a[0] == 0) begin
            m_base[a[2:1]] = d[31:6]; m_en[a[2:1]] = d[0]; m_done[a[2:1]] = 0;
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_raddr = a;
        #0.5 chk(reg_rdata, exp, req);
    endtask

    task automatic arm(input int s);
        logic [31:0] b = {$urandom(), 6'b0} | 32'h3E;
        wr_reg(3'(s * 2), b | 32'h1);   // R11/R3: bits 5:1 set as junk
    endtask

    task automatic send(input int len, input logic [7:0] e, input logic mc, input logic bc,
                        input int arm_at);
        logic drop = !m_en[m_idx];
        logic [1:0] s = m_idx;
        logic [7:0] seed = 8'($urandom());
        for (int b = 0; b < len; b++) begin
            logic acc = 0;
            if (b == arm_at) arm(m_idx);
            while (!acc) begin
                logic exp_mv;
                @(negedge clk);
                rx_valid = 1; rx_data = seed + 8'(b * 7); rx_last = (b == len - 1);
                rx_err = e; rx_mcast = mc; rx_bcast = bc;
                mem_ready = ($urandom() % 4) != 0;
                #0.5;
                exp_mv = !drop && (b < BUF);
                chk({31'b0, mem_valid}, {31'b0, exp_mv}, drop ? "R8 mem_valid" : "R10/R4 mem_valid");
                if (exp_mv) begin
                    chk(mem_addr, {m_base[s], 6'b0} + 32'(b), "R4 addr");
                    chk({24'b0, mem_data}, {24'b0, rx_data}, "R4 data");
                end
                chk({31'b0, rx_ready}, {31'b0, exp_mv ? mem_ready : 1'b1}, "R4 ready");
                acc = rx_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        rx_valid = 0; rx_last = 0;
        #0.5 chk({31'b0, slot_done_pulse}, {31'b0, !drop}, "R5 pulse");
        if (!drop) begin
            m_stat[s] = exp_status(len, e, mc, bc, m_missed);
            m_done[s] = 1; m_en[s] = 0; m_idx = m_idx + 1; m_missed = 0;
        end else m_missed = 1;
        @(negedge clk);
        #0.5 chk({31'b0, slot_done_pulse}, 0, "R5 pulse width");
        rd_chk(3'(s * 2 + 1), m_stat[s], "R5/R7/R9 status");
        rd_chk(3'(s * 2), exp_ctrl(s), "R6 ctrl");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin
            m_base[i] = 0; m_en[i] = 0; m_done[i] = 0; m_stat[i] = 0;
        end
        repeat (3) @(posedge clk);
        #0.5 rst = 0;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 0, "R1 reset");
        chk({31'b0, slot_done_pulse}, 0, "R1 pulse");
        // R2 status is read-only
        wr_reg(3'd1, 32'hFFFF_FFFF);
        rd_chk(3'd1, 0, "R2 status write ignored");
        rd_chk(3'd0, 0, "R2 ctrl untouched");
        // R3 arm all and read back
        for (int i = 0; i < 4; i++) begin
            arm(i);
            rd_chk(3'(i * 2), exp_ctrl(i), "R3 ctrl readback");
        end
        // R4-R7 directed: four frames, wrap to slot 0
        send(1, 8'h00, 0, 0, -1);
        send(64, 8'h21, 1, 0, -1);
        send(60, 8'hDE, 0, 1, -1);
        send(100, 8'h01, 1, 1, -1);
        chk({30'b0, m_idx}, 0, "R6 wrap");
        rd_chk(3'd0, exp_ctrl(0), "R6 index wrapped");
        // R8 dropped frame, armed mid-frame
        send(20, 8'h00, 0, 0, 5);
        // R9 missed flag on next, then cleared
        send(30, 8'h00, 0, 0, -1);
        arm(1);
        send(30, 8'h00, 0, 0, -1);
        // R10 over-length
        arm(2);
        send(200, 8'h00, 0, 0, -1);
        // random traffic with re-arm (R11)
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < 4; i++)
                if (!m_en[i] && ($urandom() % 3) != 0) arm(i);
            send(1 + int'($urandom() % 150), 8'($urandom()), 1'($urandom()), 1'($urandom()), -1);
        end
        for (int i = 0; i < 4; i++) begin
            rd_chk(3'(i * 2), exp_ctrl(i), "R11 final ctrl");
            rd_chk(3'(i * 2 + 1), m_stat[i], "R7 final status");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule